// File: doc/BRIEF.md
# Split-Byte Double-Buffered Converter Front End

This block is the digital front end of a 12-bit converter that sits on an 8-bit bus. A 12-bit staging register is filled in two pieces. Its low 8 bits come in under one active-low select and its top 4 bits under a second active-low select. Both pieces are gated by one shared active-low write strobe. Each piece follows the bus for as long as it is selected. It freezes on whichever of the strobe or its own select goes high first.

The top 4 bits arrive on the four lowest bus lines. Those lines therefore serve as staging bits 3..0 in a byte write and as staging bits 11..8 in a nibble write.

A separate active-low load strobe copies the staging register into the 12-bit output register that feeds the converter. Two active-low force inputs drive the output register to all ones or all zeros without touching the staging register. All control and data inputs are asynchronous. Each passes through a synchronizer clocked by a fast system clock, and the level-sensitive latches are modelled as registers on that clock. An input change reaches the registers on the third rising clock edge after it is applied.

Top module: `sdac_front`

## Requirements
- R1: After reset, both the staging register and the output register read zero.
- R2: While the low-byte select and the write strobe are both low and the nibble select is high, staging bits 7..0 follow bus bits 7..0.
- R3: While the nibble select and the write strobe are both low and the low-byte select is high, staging bits 11..8 follow bus bits 3..0.
- R4: A piece that was being written keeps its value once the write strobe or its own select goes high, even if the bus changes afterwards.
- R5: With the write strobe high, or with both selects high, the staging register does not change.
- R6: With both selects and the write strobe low together, the write is treated as illegal and the staging register does not change.
- R7: While the load strobe is low and both force inputs are high, the output register takes the staging register value, whatever the write strobe and selects are doing.
- R8: While force-ones is low, the output register becomes all ones, overriding force-zeros and load, and the staging register is untouched.
- R9: While force-zeros is low and force-ones is high, the output register becomes all zeros, overriding load, and the staging register is untouched.
- R10: With load, force-ones and force-zeros all high, the output register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_d | input | 8 | Shared data bus |
| sel_lo_n | input | 1 | Active-low select for staging bits 7..0 |
| sel_hi_n | input | 1 | Active-low select for staging bits 11..8 |
| wr_n | input | 1 | Active-low shared write strobe |
| xfer_n | input | 1 | Active-low load of staging into output register |
| force1_n | input | 1 | Active-low force of output register to all ones |
| force0_n | input | 1 | Active-low force of output register to all zeros |
| stage_q | output | 12 | Staging register value |
| dac_q | output | 12 | Output register value driving the converter |

## Verification
The bench changes the bus after each close, both with the strobe rising first and with the select rising first. A design that stayed transparent past either edge would show the late bus value. It drives a nibble write whose upper bus bits differ from the lower ones, which exposes a design that takes the nibble from the wrong lines. It also drives both selects low at once, which a naive decoder would treat as a write to both pieces. Finally it drives load together with one or both force inputs and loads while a byte write is open, so any swap in the set-clear-load priority, or any gating of load by the write strobe, yields a wrong output register value.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int DAC_W = 12;
  localparam int BUS_W = 8;
  localparam int HI_W  = DAC_W - BUS_W;

  // Replace the low piece of the staging word with a bus byte.
  function automatic logic [DAC_W-1:0] put_low(input logic [DAC_W-1:0] cur,
                                               input logic [BUS_W-1:0] bus);
    return {cur[DAC_W-1:BUS_W], bus};
  endfunction

  // Replace the high piece with the lowest bus lines.
  function automatic logic [DAC_W-1:0] put_high(input logic [DAC_W-1:0] cur,
                                                input logic [BUS_W-1:0] bus);
    return {bus[HI_W-1:0], cur[BUS_W-1:0]};
  endfunction
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[s] <= RST_VAL;
        else        pipe[s] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[s] <= RST_VAL;
        else        pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sdac_stage.sv
module sdac_stage
  import sdac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] bus_s,
  input  logic             lo_n_s,
  input  logic             hi_n_s,
  input  logic             wr_n_s,
  output logic [DAC_W-1:0] stage_q
);
  logic low_open, high_open, illegal_wr;
  logic low_open_q, high_open_q;
  logic low_close, high_close;

  assign low_open   = !wr_n_s && !lo_n_s &&  hi_n_s;
  assign high_open  = !wr_n_s && !hi_n_s &&  lo_n_s;
  assign illegal_wr = !wr_n_s && !hi_n_s && !lo_n_s;
  assign low_close  = low_open_q  && !low_open;
  assign high_close = high_open_q && !high_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q     <= '0;
      low_open_q  <= 1'b0;
      high_open_q <= 1'b0;
    end else begin
      low_open_q  <= low_open;
      high_open_q <= high_open;
      if (low_open)       stage_q <= put_low(stage_q, bus_s);
      else if (high_open) stage_q <= put_high(stage_q, bus_s);
    end
  end

  assert_low_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    low_open |=> stage_q[BUS_W-1:0] == $past(bus_s));
  assert_high_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    high_open |=> stage_q[DAC_W-1:BUS_W] == $past(bus_s[HI_W-1:0]));
  assert_low_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    low_close |=> $stable(stage_q[BUS_W-1:0]));
  assert_high_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    high_close |=> $stable(stage_q[DAC_W-1:BUS_W]));
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_n_s || (lo_n_s && hi_n_s)) |=> $stable(stage_q));
  assert_illegal_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_wr |=> $stable(stage_q));
  assert_one_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({low_open, high_open}));
endmodule

// File: rtl/sdac_out.sv
module sdac_out
  import sdac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DAC_W-1:0] stage_q,
  input  logic             xfer_n_s,
  input  logic             f1_n_s,
  input  logic             f0_n_s,
  output logic [DAC_W-1:0] dac_q
);
  logic force_ones, force_zeros, do_load;

  assign force_ones  = !f1_n_s;
  assign force_zeros =  f1_n_s && !f0_n_s;
  assign do_load     =  f1_n_s &&  f0_n_s && !xfer_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           dac_q <= '0;
    else if (force_ones)  dac_q <= '1;
    else if (force_zeros) dac_q <= '0;
    else if (do_load)     dac_q <= stage_q;
  end

  assert_load_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (f1_n_s && f0_n_s && !xfer_n_s) |=> dac_q == $past(stage_q));
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !f1_n_s |=> &dac_q);
  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (f1_n_s && !f0_n_s) |=> dac_q == '0);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (f1_n_s && f0_n_s && xfer_n_s) |=> $stable(dac_q));
endmodule

// File: rtl/sdac_front.sv
module sdac_front
  import sdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] bus_d,
  input  logic             sel_lo_n,
  input  logic             sel_hi_n,
  input  logic             wr_n,
  input  logic             xfer_n,
  input  logic             force1_n,
  input  logic             force0_n,
  output logic [DAC_W-1:0] stage_q,
  output logic [DAC_W-1:0] dac_q
);
  localparam int CTRL_W = 6;

  logic [CTRL_W-1:0] ctrl_s;
  logic [BUS_W-1:0]  bus_s;

  // Controls reset to their inactive (high) level.
  sdac_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL({CTRL_W{1'b1}})) u_ctrl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sel_lo_n, sel_hi_n, wr_n, xfer_n, force1_n, force0_n}),
    .q(ctrl_s));

  // Data takes the same delay so it lines up with the strobes.
  sdac_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_d), .q(bus_s));

  sdac_stage u_stage (
    .clk(clk), .rst_n(rst_n), .bus_s(bus_s),
    .lo_n_s(ctrl_s[5]), .hi_n_s(ctrl_s[4]), .wr_n_s(ctrl_s[3]),
    .stage_q(stage_q));

  sdac_out u_out (
    .clk(clk), .rst_n(rst_n), .stage_q(stage_q),
    .xfer_n_s(ctrl_s[2]), .f1_n_s(ctrl_s[1]), .f0_n_s(ctrl_s[0]),
    .dac_q(dac_q));

  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (stage_q == '0 && dac_q == '0));
endmodule

// File: tb/sdac_front_tb_top.sv
module sdac_front_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_d = 8'h00;
  logic        sel_lo_n = 1'b1, sel_hi_n = 1'b1, wr_n = 1'b1;
  logic        xfer_n = 1'b1, force1_n = 1'b1, force0_n = 1'b1;
  logic [11:0] stage_q, dac_q;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [11:0] exp_stage = 12'h000;
  logic [11:0] exp_dac   = 12'h000;

  logic [11:0] q_stage [$];
  logic [11:0] q_dac   [$];
  string       q_tag   [$];

  always #2.5 clk = ~clk;

  sdac_front dut_i (
    .clk(clk), .rst_n(rst_n), .bus_d(bus_d),
    .sel_lo_n(sel_lo_n), .sel_hi_n(sel_hi_n), .wr_n(wr_n),
    .xfer_n(xfer_n), .force1_n(force1_n), .force0_n(force0_n),
    .stage_q(stage_q), .dac_q(dac_q));

  // Driver: apply pins after a falling edge, then let them settle.
  task automatic drive(input logic [7:0] b, input logic lo, input logic hi,
                       input logic wr, input logic xf, input logic f1,
                       input logic f0);
    @(negedge clk);
    bus_d = b; sel_lo_n = lo; sel_hi_n = hi; wr_n = wr;
    xfer_n = xf; force1_n = f1; force0_n = f0;
    repeat (6) @(posedge clk);
  endtask

  // Push the expected pair; the monitor compares at the next falling edge.
  task automatic expect_now(input string tag);
    @(posedge clk);
    #1;
    q_stage.push_back(exp_stage);
    q_dac.push_back(exp_dac);
    q_tag.push_back(tag);
  endtask

  // Monitor / scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      while (q_tag.size() > 0) begin
        logic [11:0] es, ed;
        string t;
        es = q_stage.pop_front();
        ed = q_dac.pop_front();
        t  = q_tag.pop_front();
        checks++;
        if (stage_q !== es || dac_q !== ed) begin
          failures++;
          $display("FAIL %s stage=%h exp %h dac=%h exp %h", t, stage_q, es, dac_q, ed);
        end
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    expect_now("R1 reset zero");

    drive(8'hA5, 0, 1, 0, 1, 1, 1);
    exp_stage = {exp_stage[11:8], 8'hA5};
    expect_now("R2 byte write");

    drive(8'h3C, 0, 1, 0, 1, 1, 1);
    exp_stage = {exp_stage[11:8], 8'h3C};
    expect_now("R2 byte transparent");

    drive(8'h3C, 0, 1, 1, 1, 1, 1);   // strobe rises first
    drive(8'h99, 0, 1, 1, 1, 1, 1);
    expect_now("R4 freeze on strobe");
    drive(8'h99, 1, 1, 1, 1, 1, 1);

    drive(8'hF7, 1, 0, 0, 1, 1, 1);
    exp_stage = {4'h7, exp_stage[7:0]};
    expect_now("R3 nibble from bus 3..0");

    drive(8'hFE, 1, 0, 0, 1, 1, 1);
    exp_stage = {4'hE, exp_stage[7:0]};
    expect_now("R3 nibble transparent");

    drive(8'hFE, 1, 1, 0, 1, 1, 1);   // select rises first
    drive(8'hF1, 1, 1, 0, 1, 1, 1);
    expect_now("R4 freeze on select");
    drive(8'hF1, 1, 1, 1, 1, 1, 1);

    drive(8'h55, 0, 1, 1, 1, 1, 1);
    expect_now("R5 strobe high ignored");
    drive(8'h55, 1, 1, 0, 1, 1, 1);
    expect_now("R5 no select ignored");

    drive(8'h66, 0, 0, 0, 1, 1, 1);
    expect_now("R6 both selects ignored");
    drive(8'h66, 1, 1, 1, 1, 1, 1);

    drive(8'h66, 1, 1, 1, 0, 1, 1);
    exp_dac = exp_stage;
    expect_now("R7 load copy");
    drive(8'h66, 1, 1, 1, 1, 1, 1);

    drive(8'h12, 0, 1, 0, 0, 1, 1);   // load during open byte write
    exp_stage = {exp_stage[11:8], 8'h12};
    exp_dac = exp_stage;
    expect_now("R7 load ignores write");
    drive(8'h12, 0, 1, 1, 1, 1, 1);
    drive(8'h12, 1, 1, 1, 1, 1, 1);

    drive(8'h77, 1, 1, 1, 1, 1, 1);
    expect_now("R10 hold");

    drive(8'h77, 1, 1, 1, 0, 0, 0);
    exp_dac = 12'hFFF;
    expect_now("R8 set beats clear and load");

    drive(8'h77, 1, 1, 1, 0, 1, 0);
    exp_dac = 12'h000;
    expect_now("R9 clear beats load");

    drive(8'h77, 1, 1, 1, 1, 1, 1);
    expect_now("R10 hold zero");

    drive(8'h77, 1, 1, 1, 1, 0, 1);
    drive(8'h77, 1, 1, 1, 1, 1, 1);
    exp_dac = 12'hFFF;
    expect_now("R10 hold ones after set");

    drive(8'h77, 1, 1, 1, 0, 1, 1);
    exp_dac = exp_stage;
    expect_now("R7 reload after force");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule